// File: doc/BRIEF.md
# Block-Based Memory Protection Controller

This block guards a downstream memory from an upstream bus master. The protected address range is cut into equal blocks. A lookup table holds one security bit per block, and secure configuration software programs it. Each upstream request carries a security attribute. When that attribute equals its block's table bit, the request goes to the downstream port unchanged and the downstream response returns upstream. When the two differ, the request is rejected and never reaches memory.

A rejected request gets its own response one cycle later. A control bit selects the kind of response. It is either an error, or a clean completion that returns zero data and discards write data. The first rejection is recorded in a status bit, together with its address and its attributes. This record is kept until software clears it. The status bit drives an interrupt output through an enable bit.

Software loads the table one 32-bit word at a time. It writes a word index, then reads or writes a data register that steps the index after every access. Only secure register accesses have any effect. Non-secure ones read zero and change nothing.

Top module: `mpc_guard`

## Requirements
- R1: A request whose security attribute matches its block's table bit appears on the downstream port in the same cycle with identical address, write flag, write data and attribute. The downstream response (valid, data, error) is returned on the upstream response port.
- R2: A request whose attribute does not match its block's table bit never raises `dn_req_o`, so a rejected write never reaches memory.
- R3: A rejected request receives `up_rsp_valid_o` in the cycle after the request, with `up_rdata_o` = 0. When control bit 0 is 0, `up_err_o` = 1. When control bit 0 is 1 (read-as-zero/write-ignored), `up_err_o` = 0.
- R4: The block number is address / BLK_BYTES. Its table bit is bit (block mod 32) of word (block / 32). A bit value of 0 means secure (`up_ns_i`=0 passes) and 1 means non-secure (`up_ns_i`=1 passes).
- R5: Register word addresses are: 0 control, 1 table index, 2 table data, 3 status, 4 clear, 5 enable, 6 fault address, 7 fault attributes, 8 table word count (read-only). A data access reads or writes the word selected by the index. After each access the index increments, wrapping from the last word to 0.
- R6: When the status bit is clear, a rejection stores its address in register 6, and its attributes in register 7 (bit 0 = write, bit 1 = non-secure). When the status bit is already set, later rejections do not change either register.
- R7: Status bit 0 is set by any rejection. Writing 1 to bit 0 of the clear register clears it, unless a rejection arrives in that same cycle.
- R8: `irq_o` is high exactly while the status bit and enable bit 0 are both 1.
- R9: After reset the table is all zero, control, enable, status and index are 0, and `irq_o` is low.
- R10: A register access with `cfg_ns_i`=1 reads 0 and changes no register, no table word and no index.
- R11: A register read returns its data on `cfg_rdata_o` from the cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| up_req_i | input | 1 | Upstream request strobe |
| up_we_i | input | 1 | Upstream write flag |
| up_ns_i | input | 1 | Upstream non-secure attribute |
| up_addr_i | input | AW | Upstream byte address |
| up_wdata_i | input | DW | Upstream write data |
| up_rsp_valid_o | output | 1 | Upstream response strobe |
| up_rdata_o | output | DW | Upstream read data |
| up_err_o | output | 1 | Upstream error response |
| dn_req_o | output | 1 | Downstream request strobe |
| dn_we_o | output | 1 | Downstream write flag |
| dn_ns_o | output | 1 | Downstream non-secure attribute |
| dn_addr_o | output | AW | Downstream byte address |
| dn_wdata_o | output | DW | Downstream write data |
| dn_rsp_valid_i | input | 1 | Downstream response strobe |
| dn_rdata_i | input | DW | Downstream read data |
| dn_err_i | input | 1 | Downstream error response |
| cfg_req_i | input | 1 | Register access strobe |
| cfg_we_i | input | 1 | Register write flag |
| cfg_ns_i | input | 1 | Register access non-secure attribute |
| cfg_addr_i | input | 4 | Register word address |
| cfg_wdata_i | input | 32 | Register write data |
| cfg_rdata_o | output | 32 | Register read data |
| irq_o | output | 1 | Rejection interrupt |

## Verification
The assertions assume that the upstream master keeps at most one request outstanding. They also assume that the downstream side raises a response only for a request it actually received, so its response never lands in the cycle that belongs to a rejection response. The directed tasks hold to this. Every upstream access waits for its response cycle before the next one is issued. The modelled memory answers exactly one cycle after each forwarded request and stays silent after rejected ones.

// File: rtl/mpc_pkg.sv
package mpc_pkg;
  typedef enum logic [3:0] {
    REG_CTRL  = 4'd0,
    REG_IDX   = 4'd1,
    REG_DATA  = 4'd2,
    REG_STAT  = 4'd3,
    REG_CLR   = 4'd4,
    REG_EN    = 4'd5,
    REG_FADDR = 4'd6,
    REG_FATTR = 4'd7,
    REG_WORDS = 4'd8
  } reg_e;

  typedef struct packed {
    logic ns;
    logic we;
  } fault_attr_t;

  localparam int unsigned TBL_W = 32;
endpackage

// File: rtl/mpc_lut.sv
module mpc_lut #(
  parameter int unsigned BLKW  = 8,
  parameter int unsigned WORDS = 8,
  parameter int unsigned IDXW  = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic [IDXW-1:0] wr_idx_i,
  input  logic [31:0]     wr_data_i,
  input  logic [IDXW-1:0] rd_idx_i,
  output logic [31:0]     rd_word_o,
  input  logic [BLKW-1:0] look_blk_i,
  output logic            look_ns_o
);
  logic [31:0] tbl_q [WORDS];

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) tbl_q[w] <= '0;
      else if (wr_en_i && wr_idx_i == IDXW'(w)) tbl_q[w] <= wr_data_i;
    end
  end

  logic [IDXW-1:0] look_word;
  logic [4:0]      look_bit;
  assign look_word = look_blk_i[BLKW-1:5];
  assign look_bit  = look_blk_i[4:0];

  assign rd_word_o = tbl_q[rd_idx_i];
  assign look_ns_o = tbl_q[look_word][look_bit];
endmodule

// File: rtl/mpc_regs.sv
module mpc_regs
  import mpc_pkg::*;
#(
  parameter int unsigned AW    = 16,
  parameter int unsigned WORDS = 8,
  parameter int unsigned IDXW  = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cfg_req_i,
  input  logic            cfg_we_i,
  input  logic            cfg_ns_i,
  input  logic [3:0]      cfg_addr_i,
  input  logic [31:0]     cfg_wdata_i,
  output logic [31:0]     cfg_rdata_o,
  input  logic            fault_i,
  input  logic [AW-1:0]   fault_addr_i,
  input  fault_attr_t     fault_attr_i,
  output logic            raz_o,
  output logic            stat_o,
  output logic            en_o,
  output logic            clr_o,
  output logic [AW-1:0]   info_addr_o,
  output logic            irq_o,
  output logic            lut_we_o,
  output logic [IDXW-1:0] lut_idx_o,
  output logic [31:0]     lut_wdata_o,
  input  logic [31:0]     lut_rword_i
);
  reg_e            sel;
  logic            sec_wr, sec_rd, data_hit, capture;
  logic            raz_q, en_q, stat_q;
  logic [IDXW-1:0] idx_q;
  logic [AW-1:0]   faddr_q;
  fault_attr_t     fattr_q;
  logic [31:0]     rdata_q, rd_mux;

  assign sel      = reg_e'(cfg_addr_i);
  assign sec_wr   = cfg_req_i & ~cfg_ns_i & cfg_we_i;
  assign sec_rd   = cfg_req_i & ~cfg_ns_i & ~cfg_we_i;
  assign data_hit = (sec_wr | sec_rd) && sel == REG_DATA;
  assign clr_o    = sec_wr && sel == REG_CLR && cfg_wdata_i[0];
  // capture when no fault is held, or the held one is cleared this cycle
  assign capture  = fault_i & (~stat_q | clr_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raz_q <= 1'b0;
      en_q  <= 1'b0;
      idx_q <= '0;
    end else begin
      if (sec_wr && sel == REG_CTRL) raz_q <= cfg_wdata_i[0];
      if (sec_wr && sel == REG_EN)   en_q  <= cfg_wdata_i[0];
      if (data_hit)                   idx_q <= idx_q + 1'b1;
      else if (sec_wr && sel == REG_IDX) idx_q <= cfg_wdata_i[IDXW-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q  <= 1'b0;
      faddr_q <= '0;
      fattr_q <= '0;
    end else begin
      if (fault_i)    stat_q <= 1'b1;
      else if (clr_o) stat_q <= 1'b0;
      if (capture) begin
        faddr_q <= fault_addr_i;
        fattr_q <= fault_attr_i;
      end
    end
  end

  always_comb begin
    case (sel)
      REG_CTRL:  rd_mux = {31'd0, raz_q};
      REG_IDX:   rd_mux = 32'(idx_q);
      REG_DATA:  rd_mux = lut_rword_i;
      REG_STAT:  rd_mux = {31'd0, stat_q};
      REG_EN:    rd_mux = {31'd0, en_q};
      REG_FADDR: rd_mux = 32'(faddr_q);
      REG_FATTR: rd_mux = {30'd0, fattr_q};
      REG_WORDS: rd_mux = 32'(WORDS);
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else if (cfg_req_i && !cfg_we_i) rdata_q <= cfg_ns_i ? 32'd0 : rd_mux;
  end

  assign cfg_rdata_o = rdata_q;
  assign raz_o       = raz_q;
  assign stat_o      = stat_q;
  assign en_o        = en_q;
  assign info_addr_o = faddr_q;
  assign irq_o       = stat_q & en_q;
  assign lut_we_o    = sec_wr && sel == REG_DATA;
  assign lut_idx_o   = idx_q;
  assign lut_wdata_o = cfg_wdata_i;
endmodule

// File: rtl/mpc_xact.sv
module mpc_xact
  import mpc_pkg::*;
#(
  parameter int unsigned AW   = 16,
  parameter int unsigned DW   = 32,
  parameter int unsigned OFFW = 8,
  parameter int unsigned BLKW = AW - OFFW
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            up_req_i,
  input  logic            up_we_i,
  input  logic            up_ns_i,
  input  logic [AW-1:0]   up_addr_i,
  input  logic [DW-1:0]   up_wdata_i,
  output logic            up_rsp_valid_o,
  output logic [DW-1:0]   up_rdata_o,
  output logic            up_err_o,
  output logic            dn_req_o,
  output logic            dn_we_o,
  output logic            dn_ns_o,
  output logic [AW-1:0]   dn_addr_o,
  output logic [DW-1:0]   dn_wdata_o,
  input  logic            dn_rsp_valid_i,
  input  logic [DW-1:0]   dn_rdata_i,
  input  logic            dn_err_i,
  input  logic            raz_i,
  output logic [BLKW-1:0] look_blk_o,
  input  logic            look_ns_i,
  output logic            fault_o,
  output fault_attr_t     fault_attr_o
);
  logic pass;
  logic rej_q, rej_err_q;

  assign look_blk_o = up_addr_i[AW-1:OFFW];
  assign pass       = (up_ns_i == look_ns_i);
  assign fault_o    = up_req_i & ~pass;
  assign fault_attr_o = '{ns: up_ns_i, we: up_we_i};

  assign dn_req_o   = up_req_i & pass;
  assign dn_we_o    = up_we_i;
  assign dn_ns_o    = up_ns_i;
  assign dn_addr_o  = up_addr_i;
  assign dn_wdata_o = up_wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rej_q     <= 1'b0;
      rej_err_q <= 1'b0;
    end else begin
      rej_q     <= fault_o;
      rej_err_q <= ~raz_i;
    end
  end

  assign up_rsp_valid_o = rej_q | dn_rsp_valid_i;
  assign up_rdata_o     = rej_q ? '0 : dn_rdata_i;
  assign up_err_o       = rej_q ? rej_err_q : dn_err_i;
endmodule

// File: rtl/mpc_guard.sv
module mpc_guard
  import mpc_pkg::*;
#(
  parameter int unsigned AW        = 16,
  parameter int unsigned DW        = 32,
  parameter int unsigned BLK_BYTES = 256
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          up_req_i,
  input  logic          up_we_i,
  input  logic          up_ns_i,
  input  logic [AW-1:0] up_addr_i,
  input  logic [DW-1:0] up_wdata_i,
  output logic          up_rsp_valid_o,
  output logic [DW-1:0] up_rdata_o,
  output logic          up_err_o,
  output logic          dn_req_o,
  output logic          dn_we_o,
  output logic          dn_ns_o,
  output logic [AW-1:0] dn_addr_o,
  output logic [DW-1:0] dn_wdata_o,
  input  logic          dn_rsp_valid_i,
  input  logic [DW-1:0] dn_rdata_i,
  input  logic          dn_err_i,
  input  logic          cfg_req_i,
  input  logic          cfg_we_i,
  input  logic          cfg_ns_i,
  input  logic [3:0]    cfg_addr_i,
  input  logic [31:0]   cfg_wdata_i,
  output logic [31:0]   cfg_rdata_o,
  output logic          irq_o
);
  // block field must span at least two table words
  localparam int unsigned OFFW  = $clog2(BLK_BYTES);
  localparam int unsigned BLKW  = AW - OFFW;
  localparam int unsigned WORDS = 2 ** (BLKW - 5);
  localparam int unsigned IDXW  = BLKW - 5;

  logic            raz, stat, en, clr, fault, lut_we, look_ns;
  logic [AW-1:0]   info_addr;
  fault_attr_t     fault_attr;
  logic [IDXW-1:0] lut_idx;
  logic [31:0]     lut_wdata, lut_rword;
  logic [BLKW-1:0] look_blk;

  mpc_lut #(.BLKW(BLKW), .WORDS(WORDS), .IDXW(IDXW)) u_lut (
    .clk_i, .rst_ni,
    .wr_en_i   (lut_we),
    .wr_idx_i  (lut_idx),
    .wr_data_i (lut_wdata),
    .rd_idx_i  (lut_idx),
    .rd_word_o (lut_rword),
    .look_blk_i(look_blk),
    .look_ns_o (look_ns)
  );

  mpc_regs #(.AW(AW), .WORDS(WORDS), .IDXW(IDXW)) u_regs (
    .clk_i, .rst_ni,
    .cfg_req_i, .cfg_we_i, .cfg_ns_i, .cfg_addr_i, .cfg_wdata_i, .cfg_rdata_o,
    .fault_i     (fault),
    .fault_addr_i(up_addr_i),
    .fault_attr_i(fault_attr),
    .raz_o       (raz),
    .stat_o      (stat),
    .en_o        (en),
    .clr_o       (clr),
    .info_addr_o (info_addr),
    .irq_o,
    .lut_we_o    (lut_we),
    .lut_idx_o   (lut_idx),
    .lut_wdata_o (lut_wdata),
    .lut_rword_i (lut_rword)
  );

  mpc_xact #(.AW(AW), .DW(DW), .OFFW(OFFW), .BLKW(BLKW)) u_xact (
    .clk_i, .rst_ni,
    .up_req_i, .up_we_i, .up_ns_i, .up_addr_i, .up_wdata_i,
    .up_rsp_valid_o, .up_rdata_o, .up_err_o,
    .dn_req_o, .dn_we_o, .dn_ns_o, .dn_addr_o, .dn_wdata_o,
    .dn_rsp_valid_i, .dn_rdata_i, .dn_err_i,
    .raz_i       (raz),
    .look_blk_o  (look_blk),
    .look_ns_i   (look_ns),
    .fault_o     (fault),
    .fault_attr_o(fault_attr)
  );
endmodule

// File: rtl/mpc_guard_chk.sv
module mpc_guard_chk #(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          up_req_i,
  input logic          dn_req_o,
  input logic          up_rsp_valid_o,
  input logic [DW-1:0] up_rdata_o,
  input logic          up_err_o,
  input logic          raz,
  input logic          stat,
  input logic          clr,
  input logic [AW-1:0] info_addr,
  input logic          irq_o,
  input logic          cfg_req_i,
  input logic          cfg_we_i,
  input logic          cfg_ns_i,
  input logic [31:0]   cfg_rdata_o
);
  AST_FWD_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dn_req_o |-> up_req_i);  // R1
  AST_REJ_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_req_i && !dn_req_o) |=> (up_rsp_valid_o && up_rdata_o == '0));  // R3
  AST_REJ_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_req_i && !dn_req_o && !raz) |=> up_err_o);  // R3
  AST_REJ_RAZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_req_i && !dn_req_o && raz) |=> !up_err_o);  // R3
  AST_STAT_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_req_i && !dn_req_o) |=> stat);  // R7
  AST_INFO_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat && !clr) |=> $stable(info_addr));  // R6
  AST_IRQ_NEEDS_STAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stat |-> !irq_o);  // R8
  AST_NS_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_req_i && cfg_ns_i && !cfg_we_i) |=> cfg_rdata_o == 32'd0);  // R10
endmodule

bind mpc_guard mpc_guard_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk_i, .rst_ni, .up_req_i, .dn_req_o, .up_rsp_valid_o, .up_rdata_o, .up_err_o,
  .raz, .stat, .clr, .info_addr, .irq_o,
  .cfg_req_i, .cfg_we_i, .cfg_ns_i, .cfg_rdata_o
);

// File: tb/mpc_guard_tb.sv
`timescale 1ns/1ps
module mpc_guard_tb;
  localparam int AW = 16;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          up_req = 0, up_we = 0, up_ns = 0;
  logic [AW-1:0] up_addr = '0;
  logic [DW-1:0] up_wdata = '0;
  logic          up_rsp_valid, up_err;
  logic [DW-1:0] up_rdata;
  logic          dn_req, dn_we, dn_ns;
  logic [AW-1:0] dn_addr;
  logic [DW-1:0] dn_wdata;
  logic          dn_rsp_valid = 0, dn_err = 0;
  logic [DW-1:0] dn_rdata = '0;
  logic          cfg_req = 0, cfg_we = 0, cfg_ns = 0;
  logic [3:0]    cfg_addr = '0;
  logic [31:0]   cfg_wdata = '0, cfg_rdata;
  logic          irq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  mpc_guard #(.AW(AW), .DW(DW), .BLK_BYTES(256)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .up_req_i(up_req), .up_we_i(up_we), .up_ns_i(up_ns), .up_addr_i(up_addr),
    .up_wdata_i(up_wdata), .up_rsp_valid_o(up_rsp_valid), .up_rdata_o(up_rdata),
    .up_err_o(up_err), .dn_req_o(dn_req), .dn_we_o(dn_we), .dn_ns_o(dn_ns),
    .dn_addr_o(dn_addr), .dn_wdata_o(dn_wdata), .dn_rsp_valid_i(dn_rsp_valid),
    .dn_rdata_i(dn_rdata), .dn_err_i(dn_err), .cfg_req_i(cfg_req), .cfg_we_i(cfg_we),
    .cfg_ns_i(cfg_ns), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
    .cfg_rdata_o(cfg_rdata), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input int k);
    return 32'h5A3C_0F81 ^ (32'h0111_1111 * k) ^ (32'h1 << k);
  endfunction

  function automatic logic [31:0] mem_val(input logic [AW-1:0] a);
    return {16'hC0DE, a};
  endfunction

  task automatic cfg_write(input logic [3:0] a, input logic [31:0] d, input logic ns);
    @(negedge clk);
    cfg_req = 1; cfg_we = 1; cfg_addr = a; cfg_wdata = d; cfg_ns = ns;
    @(negedge clk);
    cfg_req = 0; cfg_we = 0; cfg_ns = 0;
  endtask

  task automatic cfg_read(input logic [3:0] a, input logic ns, output logic [31:0] d);
    @(negedge clk);
    cfg_req = 1; cfg_we = 0; cfg_addr = a; cfg_ns = ns;
    @(negedge clk);
    cfg_req = 0; cfg_ns = 0;
    #1 d = cfg_rdata;
  endtask

  // one upstream access; reports forward decision and response
  task automatic up_access(input logic [AW-1:0] a, input logic we, input logic ns,
                           input logic [DW-1:0] wd, output bit fwd,
                           output bit rv, output logic [DW-1:0] rd, output bit er);
    @(negedge clk);
    up_req = 1; up_we = we; up_ns = ns; up_addr = a; up_wdata = wd;
    #1 fwd = dn_req;
    if (fwd) begin
      chk(dn_addr == a && dn_we == we && dn_ns == ns && dn_wdata == wd, "R1 fields",
          {dn_we, dn_ns, dn_addr, dn_wdata}, {we, ns, a, wd});
    end
    @(negedge clk);
    up_req = 0;
    if (fwd) begin
      dn_rsp_valid = 1; dn_rdata = we ? '0 : mem_val(a); dn_err = 0;
    end
    #1 rv = up_rsp_valid; rd = up_rdata; er = up_err;
    @(negedge clk);
    dn_rsp_valid = 0; dn_rdata = '0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk(irq == 0, "R9 irq", irq, 0);
    cfg_read(4'd0, 0, d); chk(d == 0, "R9 ctrl", d, 0);
    cfg_read(4'd5, 0, d); chk(d == 0, "R9 en", d, 0);
    cfg_read(4'd3, 0, d); chk(d == 0, "R9 stat", d, 0);
    cfg_read(4'd1, 0, d); chk(d == 0, "R9 idx", d, 0);
    cfg_read(4'd8, 0, d); chk(d == 8, "R5 word count", d, 8);
    for (int k = 0; k < 8; k++) begin
      cfg_read(4'd2, 0, d); chk(d == 0, "R9 table zero", d, 0);
    end
    cfg_read(4'd1, 0, d); chk(d == 0, "R5 idx wrap", d, 0);
  endtask

  task automatic t_basic();
    bit f, rv, er; logic [DW-1:0] rd; logic [31:0] d;
    up_access(16'h0010, 0, 0, '0, f, rv, rd, er);
    chk(f, "R1 secure fwd", f, 1);
    chk(rv && rd == mem_val(16'h0010) && !er, "R1 response", {rv, er, rd}, {2'b10, mem_val(16'h0010)});
    up_access(16'h0124, 1, 1, 32'hDEAD_BEEF, f, rv, rd, er);
    chk(!f, "R2 ns blocked", f, 0);
    chk(rv && rd == 0 && er, "R3 error rsp", {rv, er, rd}, {2'b11, 32'd0});
    cfg_read(4'd3, 0, d); chk(d == 1, "R7 stat set", d, 1);
    cfg_read(4'd6, 0, d); chk(d == 32'h0124, "R6 faddr", d, 32'h0124);
    cfg_read(4'd7, 0, d); chk(d == 3, "R6 fattr", d, 3);
    chk(irq == 0, "R8 irq disabled", irq, 0);
    cfg_write(4'd4, 1, 0);
    cfg_read(4'd3, 0, d); chk(d == 0, "R7 clear", d, 0);
  endtask

  task automatic t_table();
    logic [31:0] d;
    cfg_write(4'd1, 0, 0);
    for (int k = 0; k < 8; k++) cfg_write(4'd2, pat(k), 0);
    cfg_read(4'd1, 0, d); chk(d == 0, "R5 idx after 8 writes", d, 0);
    cfg_write(4'd1, 3, 0);
    cfg_read(4'd2, 0, d); chk(d == pat(3), "R5 word3", d, pat(3));
    cfg_read(4'd1, 0, d); chk(d == 4, "R5 idx incr", d, 4);
    cfg_write(4'd1, 7, 0);
    cfg_read(4'd2, 0, d); chk(d == pat(7), "R5 word7", d, pat(7));
    cfg_read(4'd2, 0, d); chk(d == pat(0), "R5 wrap read", d, pat(0));
  endtask

  task automatic t_lookup();
    bit f, rv, er; logic [DW-1:0] rd;
    logic [AW-1:0] addrs [6] = '{16'h0000, 16'h1F33, 16'h2A00, 16'h5FFF, 16'h8100, 16'hFFFC};
    foreach (addrs[i]) begin
      logic [7:0] blk; logic b;
      blk = addrs[i][15:8];
      b = pat(int'(blk[7:5]))[blk[4:0]];
      up_access(addrs[i], 0, b, '0, f, rv, rd, er);
      chk(f && rv && rd == mem_val(addrs[i]), "R4 match passes", {f, rv}, 2'b11);
      up_access(addrs[i], 0, ~b, '0, f, rv, rd, er);
      chk(!f && rv && er, "R4 mismatch rejected", {f, rv, er}, 3'b011);
    end
    cfg_write(4'd4, 1, 0);
  endtask

  task automatic t_capture();
    bit f, rv, er; logic [DW-1:0] rd; logic [31:0] d;
    // word0 bit0 is pat(0)[0]; pick block 0 wrong attribute
    logic b0;
    b0 = pat(0)[0];
    up_access(16'h0044, 0, ~b0, '0, f, rv, rd, er);
    up_access(16'h0088, 1, ~b0, '0, f, rv, rd, er);
    cfg_read(4'd6, 0, d); chk(d == 32'h0044, "R6 first kept", d, 32'h0044);
    cfg_read(4'd7, 0, d); chk(d == {30'd0, ~b0, 1'b0}, "R6 first attr", d, {30'd0, ~b0, 1'b0});
    cfg_write(4'd4, 1, 0);
    up_access(16'h0088, 1, ~b0, '0, f, rv, rd, er);
    cfg_read(4'd6, 0, d); chk(d == 32'h0088, "R6 recapture", d, 32'h0088);
    cfg_write(4'd4, 1, 0);
  endtask

  task automatic t_irq();
    bit f, rv, er; logic [DW-1:0] rd; logic b0;
    b0 = pat(0)[0];
    cfg_write(4'd5, 1, 0);
    chk(irq == 0, "R8 no stat", irq, 0);
    up_access(16'h0004, 0, ~b0, '0, f, rv, rd, er);
    chk(irq == 1, "R8 irq high", irq, 1);
    @(negedge clk); #1 chk(irq == 1, "R8 irq held", irq, 1);
    cfg_write(4'd4, 1, 0);
    #1 chk(irq == 0, "R8 irq cleared", irq, 0);
    cfg_write(4'd5, 0, 0);
  endtask

  task automatic t_raz();
    bit f, rv, er; logic [DW-1:0] rd; logic b0;
    b0 = pat(0)[0];
    cfg_write(4'd0, 1, 0);
    up_access(16'h0008, 0, ~b0, '0, f, rv, rd, er);
    chk(!f && rv && rd == 0 && !er, "R3 raz read", {f, rv, er, rd}, {3'b010, 32'd0});
    up_access(16'h000C, 1, ~b0, 32'h1234_5678, f, rv, rd, er);
    chk(!f, "R2 write dropped", f, 0);
    chk(rv && !er, "R3 wi rsp", {rv, er}, 2'b10);
    cfg_write(4'd4, 1, 0);
  endtask

  task automatic t_ns_cfg();
    logic [31:0] d; bit f, rv, er; logic [DW-1:0] rd; logic b0;
    b0 = pat(0)[0];
    cfg_read(4'd0, 1, d); chk(d == 0, "R10 ns read zero", d, 0);
    cfg_write(4'd0, 0, 1);
    cfg_read(4'd0, 0, d); chk(d == 1, "R10 ctrl unchanged", d, 1);
    cfg_write(4'd1, 2, 0);
    cfg_write(4'd2, 32'hFFFF_FFFF, 1);
    cfg_read(4'd1, 0, d); chk(d == 2, "R10 idx unchanged", d, 2);
    cfg_read(4'd2, 0, d); chk(d == pat(2), "R10 table unchanged", d, pat(2));
    up_access(16'h0000, 0, ~b0, '0, f, rv, rd, er);
    cfg_write(4'd4, 1, 1);
    cfg_read(4'd3, 0, d); chk(d == 1, "R10 ns clear ignored", d, 1);
    cfg_write(4'd4, 1, 0);
    cfg_read(4'd3, 0, d); chk(d == 0, "R11 stat read", d, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_basic();
    t_table();
    t_lookup();
    t_capture();
    t_irq();
    t_raz();
    t_ns_cfg();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule